// File: doc/BRIEF.md
# Channel Offset/Gain Correction with DC Offset Self-Calibration

This block sits in one measurement channel of a metering datapath. Every signed instantaneous sample that arrives with a valid strobe has a programmable DC offset added to it. The sum is then scaled by a programmable unsigned gain, and the result is saturated and presented one clock later as a corrected sample. A chip with several channels places one instance per channel. Each instance keeps its own offset and gain, so calibrating one channel never touches another.

On command, the block runs a DC offset calibration. It first lets a fixed number of incoming samples pass as settling. It then sums the next N raw samples, where N comes from a cycle-count register. The gain is treated as exactly 1.0 and the stored offset is left out, so the result cancels the channel's DC level whatever the offset held before. A bit-serial divider forms the mean, truncated toward zero. The negated mean is written to the offset register and a sticky data-ready bit is set. An interrupt output reports that bit when a mask bit allows it.

Top module: `ofc_engine`

## Requirements
- R1: `corr_data` equals `(smp_data + offset) * gain` arithmetically shifted right by 22 (rounding toward minus infinity). The gain is unsigned, with 0x400000 meaning 1.0. `corr_valid` is high exactly one clock after each cycle in which `smp_valid` is high, and `corr_data` carries that sample's result.
- R2: The corrected value saturates to 0x7FFFFF and 0x800000 (24-bit two's complement). This includes the case where the offset addition alone leaves the 24-bit range.
- R3: The register write map is as follows. Address 0 holds the offset (24-bit signed). Address 1 holds the gain. Address 2 holds N in the low 16 bits. Address 3 holds the interrupt mask in bit 0. Address 4 is the status register, where writing 1 to bit 0 clears data-ready. At address 5, writing 1 to bit 0 starts a calibration. Reset values are offset 0, gain 0x400000, N 0, mask 0 and data-ready 0.
- R4: After a start command, the first 30 valid samples are discarded and do not affect the result.
- R5: The next N valid samples are summed raw: offset not applied, gain held at unity. N is captured at the start command, and N = 0 is treated as 1.
- R6: On completion, the offset register receives the negation of (sum / N) truncated toward zero, saturated to 24 bits. The gain register is unchanged.
- R7: Completion takes at least N + 30 valid samples after the command. On completion `drdy` is set. `cal_busy` is high from the cycle after the command until completion.
- R8: `drdy` is sticky. Only a status write with bit 0 set clears it, and a completion in the same cycle wins over the clear.
- R9: `irq` is high exactly when `drdy` and the mask bit are both set.
- R10: A start command that arrives while a calibration is running is ignored.
- R11: After a calibration with the gain at 1.0, corrected samples of the same DC input plus small noise sum to within N of zero, which is a mean within 1 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed instantaneous sample |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Register write data |
| corr_valid | output | 1 | Corrected sample strobe |
| corr_data | output | 24 | Corrected signed sample |
| offset_out | output | 24 | Current offset register value |
| cal_busy | output | 1 | Calibration in progress |
| drdy | output | 1 | Sticky data-ready status |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest situation to reach from the ports is a second start command that lands in the middle of the accumulation window. It only matters if it would restart settling and silently push completion out. The stimulus issues that command after two of five accumulated samples. It then checks that data-ready rises and the expected offset appears after only the remaining three. Truncation toward zero is only visible with a negative sum that is not divisible by N. A mean of -300.6 is therefore fed, which must yield +300 rather than +301. Large settling samples and a gain of 2.0 during calibration show that neither leaks into the result.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  localparam int SMP_W      = 24;
  localparam int GAIN_W     = 24;
  localparam int GAIN_FRAC  = 22;
  localparam int CNT_W      = 16;
  localparam int SETTLE_NUM = 30;
  localparam int ADDR_W     = 3;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETTLE = 3'd1,
    PH_ACCUM  = 3'd2,
    PH_LAUNCH = 3'd3,
    PH_DIVIDE = 3'd4
  } cal_phase_t;

  typedef enum logic [2:0] {
    RA_OFFSET = 3'd0,
    RA_GAIN   = 3'd1,
    RA_COUNT  = 3'd2,
    RA_MASK   = 3'd3,
    RA_STATUS = 3'd4,
    RA_CMD    = 3'd5
  } reg_addr_t;
endpackage

// File: rtl/ofc_corrector.sv
module ofc_corrector #(
  parameter int SW = 24,
  parameter int GW = 24,
  parameter int GF = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_data,
  input  logic signed [SW-1:0] offset,
  input  logic [GW-1:0]        gain,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_data
);
  localparam int SUMW = SW + 1;
  localparam int PW   = SUMW + GW + 1;
  localparam logic signed [PW-1:0] MAXV = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  // add offset, scale by unsigned fixed-point gain, floor shift, clamp
  function automatic logic signed [SW-1:0] apply_corr(
    input logic signed [SW-1:0] x,
    input logic signed [SW-1:0] off,
    input logic [GW-1:0]        g
  );
    logic signed [SUMW-1:0] s;
    logic signed [PW-1:0]   p;
    logic signed [PW-1:0]   sh;
    s  = SUMW'(x) + SUMW'(off);
    p  = PW'(s) * PW'($signed({1'b0, g}));
    sh = p >>> GF;
    if (sh > MAXV)      apply_corr = MAXV[SW-1:0];
    else if (sh < MINV) apply_corr = MINV[SW-1:0];
    else                apply_corr = sh[SW-1:0];
  endfunction

  logic signed [SW-1:0] corr_now;
  assign corr_now = apply_corr(in_data, offset, gain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= corr_now;
    end
  end
endmodule

// File: rtl/ofc_divider.sv
module ofc_divider #(
  parameter int DW = 40,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quotient
);
  localparam int CTW = $clog2(DW + 1);

  logic [VW:0]    rem_q;
  logic [DW-1:0]  quo_q;
  logic [VW-1:0]  div_q;
  logic [CTW-1:0] cnt_q;
  logic [VW:0]    shifted;
  logic           fits;
  logic [VW:0]    rem_next;

  assign shifted  = {rem_q[VW-1:0], quo_q[DW-1]};
  assign fits     = shifted >= {1'b0, div_q};
  assign rem_next = fits ? (shifted - {1'b0, div_q}) : shifted;
  assign busy     = cnt_q != '0;
  assign quotient = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem_q <= '0;
        quo_q <= dividend;
        div_q <= divisor;
        cnt_q <= CTW'(DW);
      end else if (busy) begin
        rem_q <= rem_next;
        quo_q <= {quo_q[DW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CTW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ofc_cal_ctrl.sv
module ofc_cal_ctrl
  import ofc_pkg::*;
#(
  parameter int SW     = 24,
  parameter int CW     = 16,
  parameter int SETTLE = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CW-1:0]        n_cfg,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_data,
  output cal_phase_t           phase,
  output logic                 div_start,
  output logic [SW+CW-1:0]     div_dividend,
  output logic [CW-1:0]        div_divisor,
  input  logic                 div_done,
  input  logic [SW+CW-1:0]     div_quo,
  output logic                 cal_done,
  output logic signed [SW-1:0] cal_result
);
  localparam int AW  = SW + CW;
  localparam int STW = $clog2(SETTLE + 1);
  localparam logic [AW-1:0] MAXQ = {{(AW-SW+1){1'b0}}, {(SW-1){1'b1}}};

  cal_phase_t           phase_q;
  logic [STW-1:0]       st_cnt;
  logic [CW-1:0]        acc_cnt;
  logic [CW-1:0]        n_lat;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_next;
  logic                 acc_neg;

  assign phase    = phase_q;
  assign acc_next = acc + AW'(smp_data);
  assign acc_neg  = acc[AW-1];

  assign div_start    = phase_q == PH_LAUNCH;
  assign div_dividend = acc_neg ? AW'(-acc) : AW'(acc);
  assign div_divisor  = n_lat;
  assign cal_done     = (phase_q == PH_DIVIDE) && div_done;

  // offset = -(mean truncated toward zero), clamped to the sample range
  always_comb begin
    if (acc_neg) cal_result = (div_quo > MAXQ) ? MAXQ[SW-1:0] : div_quo[SW-1:0];
    else         cal_result = -div_quo[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      st_cnt  <= '0;
      acc_cnt <= '0;
      n_lat   <= '0;
      acc     <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SETTLE;
          st_cnt  <= '0;
          n_lat   <= (n_cfg == '0) ? CW'(1) : n_cfg;
        end
        PH_SETTLE: if (smp_valid) begin
          if (st_cnt == STW'(SETTLE - 1)) begin
            phase_q <= PH_ACCUM;
            acc     <= '0;
            acc_cnt <= '0;
          end else begin
            st_cnt <= st_cnt + 1'b1;
          end
        end
        PH_ACCUM: if (smp_valid) begin
          acc     <= acc_next;
          acc_cnt <= acc_cnt + 1'b1;
          if (acc_cnt == n_lat - 1'b1) phase_q <= PH_LAUNCH;
        end
        PH_LAUNCH: phase_q <= PH_DIVIDE;
        PH_DIVIDE: if (div_done) phase_q <= PH_IDLE;
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ofc_engine.sv
module ofc_engine
  import ofc_pkg::*;
#(
  parameter int SW     = SMP_W,
  parameter int GW     = GAIN_W,
  parameter int GF     = GAIN_FRAC,
  parameter int CW     = CNT_W,
  parameter int SETTLE = SETTLE_NUM,
  parameter int AWID   = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [SW-1:0]   smp_data,
  input  logic            reg_wr,
  input  logic [AWID-1:0] reg_addr,
  input  logic [SW-1:0]   reg_wdata,
  output logic            corr_valid,
  output logic [SW-1:0]   corr_data,
  output logic [SW-1:0]   offset_out,
  output logic            cal_busy,
  output logic            drdy,
  output logic            irq
);
  localparam int DVW = SW + CW;
  localparam logic [GW-1:0] GAIN_ONE = GW'(1) << GF;

  logic signed [SW-1:0] offset_q;
  logic [GW-1:0]        gain_q;
  logic [CW-1:0]        count_q;
  logic                 mask_q;
  logic                 drdy_q;

  // named events for the checker
  logic                 start_cmd;
  logic                 clear_cmd;
  logic                 cal_done;
  logic signed [SW-1:0] cal_result;
  cal_phase_t           phase;

  logic                 div_start;
  logic [DVW-1:0]       div_dividend;
  logic [CW-1:0]        div_divisor;
  logic                 div_busy;
  logic                 div_done;
  logic [DVW-1:0]       div_quo;
  logic signed [SW-1:0] corr_s;

  assign start_cmd = reg_wr && (reg_addr == AWID'(RA_CMD)) && reg_wdata[0];
  assign clear_cmd = reg_wr && (reg_addr == AWID'(RA_STATUS)) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      gain_q   <= GAIN_ONE;
      count_q  <= '0;
      mask_q   <= 1'b0;
      drdy_q   <= 1'b0;
    end else begin
      if (cal_done) offset_q <= cal_result;
      else if (reg_wr && reg_addr == AWID'(RA_OFFSET)) offset_q <= reg_wdata;
      if (reg_wr && reg_addr == AWID'(RA_GAIN))  gain_q  <= reg_wdata[GW-1:0];
      if (reg_wr && reg_addr == AWID'(RA_COUNT)) count_q <= reg_wdata[CW-1:0];
      if (reg_wr && reg_addr == AWID'(RA_MASK))  mask_q  <= reg_wdata[0];
      if (cal_done)       drdy_q <= 1'b1;
      else if (clear_cmd) drdy_q <= 1'b0;
    end
  end

  ofc_corrector #(.SW(SW), .GW(GW), .GF(GF)) u_corr (
    .clk(clk), .rst_n(rst_n),
    .in_valid(smp_valid), .in_data(smp_data),
    .offset(offset_q), .gain(gain_q),
    .out_valid(corr_valid), .out_data(corr_s)
  );

  ofc_cal_ctrl #(.SW(SW), .CW(CW), .SETTLE(SETTLE)) u_cal (
    .clk(clk), .rst_n(rst_n),
    .start(start_cmd), .n_cfg(count_q),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .phase(phase),
    .div_start(div_start), .div_dividend(div_dividend), .div_divisor(div_divisor),
    .div_done(div_done), .div_quo(div_quo),
    .cal_done(cal_done), .cal_result(cal_result)
  );

  ofc_divider #(.DW(DVW), .VW(CW)) u_div (
    .clk(clk), .rst_n(rst_n),
    .start(div_start), .dividend(div_dividend), .divisor(div_divisor),
    .busy(div_busy), .done(div_done), .quotient(div_quo)
  );

  assign corr_data  = corr_s;
  assign offset_out = offset_q;
  assign cal_busy   = phase != PH_IDLE;
  assign drdy       = drdy_q;
  assign irq        = drdy_q & mask_q;
endmodule

// File: rtl/ofc_engine_chk.sv
module ofc_engine_chk #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          corr_valid,
  input logic [SW-1:0] offset_out,
  input logic          cal_busy,
  input logic          drdy,
  input logic          irq,
  input logic          start_cmd,
  input logic          clear_cmd,
  input logic          cal_done,
  input logic [SW-1:0] cal_result,
  input logic [2:0]    phase
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> corr_valid);
  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !corr_valid);
  assert_offset_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> offset_out == $past(cal_result));
  assert_drdy_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> drdy);
  assert_done_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> cal_busy);
  assert_busy_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> $past(start_cmd));
  assert_drdy_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy && !clear_cmd) |=> drdy);
  assert_irq_needs_drdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> drdy);
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && phase == ofc_pkg::PH_ACCUM) |=> phase != ofc_pkg::PH_SETTLE);
endmodule

bind ofc_engine ofc_engine_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .corr_valid(corr_valid),
  .offset_out(offset_out), .cal_busy(cal_busy), .drdy(drdy), .irq(irq),
  .start_cmd(start_cmd), .clear_cmd(clear_cmd), .cal_done(cal_done),
  .cal_result(cal_result), .phase(phase)
);

// File: tb/ofc_engine_test.sv
`timescale 1ns/1ps
module ofc_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic        corr_valid, cal_busy, drdy, irq;
  logic [23:0] corr_data, offset_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ofc_engine uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .corr_valid(corr_valid), .corr_data(corr_data), .offset_out(offset_out),
    .cal_busy(cal_busy), .drdy(drdy), .irq(irq)
  );

  // {sample, offset, gain, expected corrected}
  localparam logic [95:0] VEC [10] = '{
    {24'h000064, 24'h000000, 24'h400000, 24'h000064},
    {24'h000064, 24'hFFFFD8, 24'h800000, 24'h000078},
    {24'hFFFC18, 24'h000000, 24'h200000, 24'hFFFE0C},
    {24'hFFFFFD, 24'h000000, 24'h200000, 24'hFFFFFE},
    {24'h7FFFFF, 24'h000000, 24'h800000, 24'h7FFFFF},
    {24'h800000, 24'h000000, 24'hC00000, 24'h800000},
    {24'h7FFFF0, 24'h000020, 24'h400000, 24'h7FFFFF},
    {24'h0003E8, 24'h000000, 24'h000000, 24'h000000},
    {24'h003039, 24'hFFCFC7, 24'h123456, 24'h000000},
    {24'h000007, 24'h000001, 24'h600000, 24'h00000C}
  };
  localparam int NOISE [8] = '{0, 1, -1, 2, -2, 3, 0, -2};

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic smp(input logic [23:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int sum;
    repeat (3) @(negedge clk);
    // R3 reset state
    chk("R3 offset reset", offset_out, 24'h0);
    chk("R3 drdy reset", {23'd0, drdy}, 24'h0);
    chk("R9 irq reset", {23'd0, irq}, 24'h0);
    chk("R1 corr_valid reset", {23'd0, corr_valid}, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 default gain is unity
    smp(24'h000123);
    chk("R3 default gain", corr_data, 24'h000123);

    // R1/R2 vector table
    foreach (VEC[i]) begin
      wr(3'd0, VEC[i][71:48]);
      wr(3'd1, VEC[i][47:24]);
      smp(VEC[i][95:72]);
      chk("R1 corr_valid", {23'd0, corr_valid}, 24'h1);
      chk((i >= 4 && i <= 6) ? "R2 saturation" : "R1 correction", corr_data, VEC[i][23:0]);
    end
    @(negedge clk);
    chk("R1 valid drops", {23'd0, corr_valid}, 24'h0);

    // Calibration 1: N=8, gain 2.0 during calibration
    wr(3'd0, 24'h000000);
    wr(3'd1, 24'h800000);
    wr(3'd2, 24'd8);
    wr(3'd5, 24'h1);
    chk("R7 busy after start", {23'd0, cal_busy}, 24'h1);
    for (int k = 0; k < 30; k++) smp(24'd5000);   // R4 settling, discarded
    for (int k = 0; k < 7; k++) smp(24'(1000 + NOISE[k]));
    chk("R7 not done before N+30", {23'd0, drdy}, 24'h0);
    smp(24'(1000 + NOISE[7]));
    repeat (60) @(negedge clk);
    chk("R7 drdy set", {23'd0, drdy}, 24'h1);
    chk("R7 busy cleared", {23'd0, cal_busy}, 24'h0);
    chk("R4 R5 R6 offset = -1000", offset_out, 24'hFFFC18);
    chk("R9 irq masked", {23'd0, irq}, 24'h0);
    smp(24'd1003);
    chk("R6 gain kept at 2.0", corr_data, 24'd6);

    // R11 residual after calibration at unity gain
    wr(3'd1, 24'h400000);
    sum = 0;
    for (int k = 0; k < 8; k++) begin
      smp(24'(1000 + NOISE[k]));
      sum += int'($signed(corr_data));
    end
    checks++;
    if (sum > 8 || sum < -8) begin
      errors++;
      $display("FAIL R11: actual sum=%0d expected |sum|<=8", sum);
    end

    // R9 / R8
    wr(3'd3, 24'h1);
    chk("R9 irq unmasked", {23'd0, irq}, 24'h1);
    wr(3'd4, 24'h0);
    chk("R8 write 0 keeps drdy", {23'd0, drdy}, 24'h1);
    wr(3'd4, 24'h1);
    chk("R8 W1C clears drdy", {23'd0, drdy}, 24'h0);
    chk("R9 irq follows clear", {23'd0, irq}, 24'h0);

    // Calibration 2: N=5, negative mean -300.6, restart attempt mid-accumulation
    wr(3'd2, 24'd5);
    wr(3'd5, 24'h1);
    for (int k = 0; k < 30; k++) smp(24'h7FFFFF);
    smp(24'hFFFED4);   // -300
    smp(24'hFFFED3);   // -301
    wr(3'd5, 24'h1);   // R10 ignored
    smp(24'hFFFED4);
    smp(24'hFFFED3);
    smp(24'hFFFED3);
    repeat (60) @(negedge clk);
    chk("R10 restart ignored, done", {23'd0, drdy}, 24'h1);
    chk("R6 truncation toward zero", offset_out, 24'd300);
    chk("R9 irq asserted", {23'd0, irq}, 24'h1);
    wr(3'd4, 24'h1);

    // Calibration 3: N=0 behaves as N=1
    wr(3'd2, 24'd0);
    wr(3'd5, 24'h1);
    for (int k = 0; k < 30; k++) smp(24'd9);
    smp(24'd77);
    repeat (60) @(negedge clk);
    chk("R5 N=0 as 1", offset_out, 24'hFFFFB3);
    chk("R7 drdy N=0", {23'd0, drdy}, 24'h1);

    finish_run();
  end
endmodule